// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps a set of hardware descriptor queues without giving any queue its own FIFO storage. Every descriptor has one entry in a shared link RAM, and that entry holds the index of the next descriptor in the same queue. The block keeps a head index, a tail index and an entry count for each queue. Software enqueues a descriptor by writing its address to the push location of a queue. It dequeues the oldest descriptor by reading the pop location of that queue, and the read returns the descriptor's address.

Addresses are turned into link indexes through a small table of descriptor regions. Each region has a base address, a descriptor count, a power-of-two descriptor size (held as its log2) and a first link index. A descriptor's index is the first index plus the offset from the base, shifted right by the size. The reverse lookup rebuilds the address when the descriptor is popped. The manager owns a contiguous range of queue numbers, starting at `QBASE` and `NQ` long. It also offers a count peek for each queue, a non-empty bitmap, and a sticky flag for pushes that were refused.

All access goes through one request/response bus. The command address carries the access space in bits [15:14]: 0 is push, 1 is pop, 2 is count peek and 3 is configuration. Bits [13:0] carry the queue number. In the configuration space, bits [13:12] select the group: 0 is the region table, 1 is the status words and 2 is the error flag. Bits [11:0] give the offset within the group.

Top module: `llq_manager`

## Requirements
- R1: A push of an address that maps into a region appends that descriptor at the tail of the queue. Pops of one queue return addresses in the order they were pushed.
- R2: A read of the pop location of a non-empty queue returns the head descriptor's address and removes it from the queue, so its count drops by one.
- R3: A read of the pop location of an empty queue returns 0 and leaves the count, the status bitmap and the error flag unchanged.
- R4: A push is dropped, leaving the count unchanged, and the error flag is set when the address matches no region. An address matches no region when it is below the base, is not a multiple of the descriptor size from the base, lies at or beyond the region's descriptor count, or maps to a link index of `NLINK` or more. When regions overlap, the lowest-numbered region decides the index.
- R5: The error flag reads as bit 0 at configuration group 2, offset 0. It stays set until a write to that location clears it.
- R6: A read in the peek space returns the current entry count of the addressed queue.
- R7: A read of configuration group 1, offset w, returns the non-empty bits of queues QBASE+32w to QBASE+32w+31, with the lowest queue in bit 0.
- R8: A queue number outside QBASE to QBASE+NQ-1 is ignored. A push to it changes no state and sets no error, and a pop or peek of it returns 0.
- R9: cmd_ready is 1 after reset. It is 0 for exactly the one cycle after each accepted command. The response to a read is presented with rsp_valid=1 for one cycle in the cycle after that.
- R10: The region table is read and written at configuration group 0, offset 4r+f. For region r, field 0 is the base address, field 1 the descriptor count, field 2 the log2 of the descriptor size (bits [4:0]) and field 3 the first link index. After reset all fields are 0.
- R11: Queues that share the link RAM stay independent. Pushes interleaved across several queues come back per queue in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_addr | input | 16 | Space [15:14], queue number or configuration group and offset [13:0] |
| cmd_wdata | input | 32 | Write data: a descriptor address or a configuration value |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |

## Verification
Call the clock edge that accepts a command the accept edge. cmd_ready is due low for the cycle straight after the accept edge. On the next edge the head, tail, count, link and error state are all updated together, cmd_ready returns high and any read response appears. The bench drives each command at a falling edge. It checks the busy cycle at the next falling edge, then checks ready, rsp_valid and rsp_data at the falling edge after that. It compares each read value with a behavioural model made of address queues and a region list. Each later command is issued only once ready is back, so every effect of a command is visible before the next command is sampled.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {SP_PUSH = 2'd0, SP_POP = 2'd1, SP_PEEK = 2'd2, SP_CFG = 2'd3} qm_space_e;
  typedef enum logic {QM_IDLE = 1'b0, QM_BUSY = 1'b1} qm_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] count;
    logic [4:0]        szlog;
    logic [DATA_W-1:0] start;
  } region_t;
endpackage

// File: rtl/qm_region_fwd.sv
module qm_region_fwd
  import qm_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int NLINK = 1024,
  localparam int LIW  = $clog2(NLINK)
) (
  input  region_t           regs [NREG],
  input  logic [DATA_W-1:0] addr,
  output logic              hit,
  output logic [LIW-1:0]    idx
);
  logic [DATA_W-1:0] off, mask, k, slot;

  // lowest region wins: scan high to low, last match overrides
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    off  = '0;
    mask = '0;
    k    = '0;
    slot = '0;
    for (int r = NREG - 1; r >= 0; r--) begin
      off  = addr - regs[r].base;
      mask = (32'd1 << regs[r].szlog) - 32'd1;
      k    = off >> regs[r].szlog;
      slot = regs[r].start + k;
      if (addr >= regs[r].base && (off & mask) == '0 && k < regs[r].count &&
          slot >= regs[r].start && slot < 32'(NLINK)) begin
        hit = 1'b1;
        idx = slot[LIW-1:0];
      end
    end
  end
endmodule

// File: rtl/qm_region_rev.sv
module qm_region_rev
  import qm_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int NLINK = 1024,
  localparam int LIW  = $clog2(NLINK)
) (
  input  region_t           regs [NREG],
  input  logic [LIW-1:0]    idx,
  output logic              hit,
  output logic [DATA_W-1:0] addr
);
  logic [DATA_W-1:0] wide, d;

  always_comb begin
    hit  = 1'b0;
    addr = '0;
    wide = DATA_W'(idx);
    d    = '0;
    for (int r = NREG - 1; r >= 0; r--) begin
      d = wide - regs[r].start;
      if (wide >= regs[r].start && d < regs[r].count) begin
        hit  = 1'b1;
        addr = regs[r].base + (d << regs[r].szlog);
      end
    end
  end
endmodule

// File: rtl/qm_link_ram.sv
module qm_link_ram #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/llq_manager.sv
module llq_manager
  import qm_pkg::*;
#(
  parameter int NQ    = 64,
  parameter int NLINK = 1024,
  parameter int NREG  = 4,
  parameter int QBASE = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_write,
  input  logic [15:0] cmd_addr,
  input  logic [31:0] cmd_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);
  localparam int QIW = $clog2(NQ);
  localparam int LIW = $clog2(NLINK);
  localparam int CW  = $clog2(NLINK + 1);
  localparam int NSW = (NQ + 31) / 32;
  localparam logic [13:0] QB = 14'(QBASE);
  localparam logic [13:0] QN = 14'(NQ);

  qm_state_e state_q, state_d;
  logic        op_wr_q;
  logic [15:0] op_addr_q;
  logic [31:0] op_data_q;
  logic        accept, busy;

  logic [LIW-1:0] head_q [NQ];
  logic [LIW-1:0] tail_q [NQ];
  logic [CW-1:0]  cnt_q  [NQ];
  region_t        regs_q [NREG];
  logic           err_q, err_d;

  assign cmd_ready = (state_q == QM_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (state_q == QM_BUSY);

  // queue decode for the incoming command (link read) and the held one
  logic [13:0]    c_qoff, o_qoff;
  logic           c_qok, o_qok;
  logic [QIW-1:0] c_qi, o_qi;
  assign c_qoff = cmd_addr[13:0] - QB;
  assign c_qok  = (cmd_addr[13:0] >= QB) && (c_qoff < QN);
  assign c_qi   = c_qok ? c_qoff[QIW-1:0] : '0;
  assign o_qoff = op_addr_q[13:0] - QB;
  assign o_qok  = (op_addr_q[13:0] >= QB) && (o_qoff < QN);
  assign o_qi   = o_qok ? o_qoff[QIW-1:0] : '0;

  qm_space_e space;
  assign space = qm_space_e'(op_addr_q[15:14]);

  logic [LIW-1:0] cur_head, cur_tail;
  logic [CW-1:0]  cur_cnt;
  assign cur_head = head_q[o_qi];
  assign cur_tail = tail_q[o_qi];
  assign cur_cnt  = cnt_q[o_qi];

  // address <-> index translation
  logic           fwd_hit, rev_hit;
  logic [LIW-1:0] fwd_idx;
  logic [31:0]    rev_addr;
  qm_region_fwd #(.NREG(NREG), .NLINK(NLINK)) u_fwd (
    .regs(regs_q), .addr(op_data_q), .hit(fwd_hit), .idx(fwd_idx));
  qm_region_rev #(.NREG(NREG), .NLINK(NLINK)) u_rev (
    .regs(regs_q), .idx(cur_head), .hit(rev_hit), .addr(rev_addr));

  // operations committed on the busy cycle's closing edge
  logic do_push, push_bad, do_pop, pop_none, link_we, err_clr;
  assign do_push  = busy && op_wr_q && space == SP_PUSH && o_qok && fwd_hit;
  assign push_bad = busy && op_wr_q && space == SP_PUSH && o_qok && !fwd_hit;
  assign do_pop   = busy && !op_wr_q && space == SP_POP && o_qok && cur_cnt != '0;
  assign pop_none = busy && !op_wr_q && space == SP_POP && !(o_qok && cur_cnt != '0);
  assign link_we  = do_push && cur_cnt != '0;
  assign err_clr  = busy && op_wr_q && space == SP_CFG && op_addr_q[13:12] == 2'd2;

  logic [LIW-1:0] link_rdata;
  qm_link_ram #(.DEPTH(NLINK)) u_link (
    .clk(clk), .we(link_we), .waddr(cur_tail), .wdata(fwd_idx),
    .raddr(head_q[c_qi]), .rdata(link_rdata));

  // control and operand registers
  always_comb begin
    state_d = state_q;
    case (state_q)
      QM_IDLE: if (accept) state_d = QM_BUSY;
      QM_BUSY: state_d = QM_IDLE;
      default: state_d = QM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= QM_IDLE;
      op_wr_q   <= 1'b0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_wr_q   <= cmd_write;
        op_addr_q <= cmd_addr;
        op_data_q <= cmd_wdata;
      end
    end
  end

  // per-queue head/tail/count
  logic [LIW-1:0] nxt_head, nxt_tail;
  logic [CW-1:0]  nxt_cnt;
  always_comb begin
    if (do_push) begin
      nxt_head = (cur_cnt == '0) ? fwd_idx : cur_head;
      nxt_tail = fwd_idx;
      nxt_cnt  = cur_cnt + CW'(1);
    end else begin
      nxt_head = link_rdata;
      nxt_tail = cur_tail;
      nxt_cnt  = cur_cnt - CW'(1);
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic q_en;
    assign q_en = (do_push || do_pop) && (o_qi == QIW'(q));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q[q] <= '0;
        tail_q[q] <= '0;
        cnt_q[q]  <= '0;
      end else if (q_en) begin
        head_q[q] <= nxt_head;
        tail_q[q] <= nxt_tail;
        cnt_q[q]  <= nxt_cnt;
      end
    end
  end

  // region table
  for (genvar r = 0; r < NREG; r++) begin : g_region
    logic r_en;
    assign r_en = busy && op_wr_q && space == SP_CFG && op_addr_q[13:12] == 2'd0 &&
                  int'(op_addr_q[11:2]) == r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[r] <= '0;
      end else if (r_en) begin
        case (op_addr_q[1:0])
          2'd0: regs_q[r].base  <= op_data_q;
          2'd1: regs_q[r].count <= op_data_q;
          2'd2: regs_q[r].szlog <= op_data_q[4:0];
          default: regs_q[r].start <= op_data_q;
        endcase
      end
    end
  end

  // sticky error
  always_comb begin
    err_d = err_q;
    if (err_clr)       err_d = 1'b0;
    else if (push_bad) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  // read response
  logic [NSW*32-1:0] ne_vec;
  always_comb begin
    ne_vec = '0;
    for (int q = 0; q < NQ; q++) ne_vec[q] = (cnt_q[q] != '0);
  end

  logic [31:0] rsp_d;
  always_comb begin
    rsp_d = '0;
    case (space)
      SP_POP:  if (do_pop && rev_hit) rsp_d = rev_addr;
      SP_PEEK: if (o_qok) rsp_d = 32'(cur_cnt);
      SP_CFG: begin
        case (op_addr_q[13:12])
          2'd0: for (int r = 0; r < NREG; r++) begin
            if (int'(op_addr_q[11:2]) == r) begin
              case (op_addr_q[1:0])
                2'd0: rsp_d = regs_q[r].base;
                2'd1: rsp_d = regs_q[r].count;
                2'd2: rsp_d = 32'(regs_q[r].szlog);
                default: rsp_d = regs_q[r].start;
              endcase
            end
          end
          2'd1: for (int w = 0; w < NSW; w++) begin
            if (int'(op_addr_q[11:0]) == w) rsp_d = ne_vec[w*32 +: 32];
          end
          2'd2: rsp_d = {31'd0, err_q};
          default: rsp_d = '0;
        endcase
      end
      default: rsp_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= busy && !op_wr_q;
      if (busy) rsp_data <= rsp_d;
    end
  end

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);
  // R9
  ready_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> cmd_ready);
  // R2
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(busy && !op_wr_q));
  // R3
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_none |=> rsp_data == 32'd0);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
  // R1
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> cnt_q[$past(o_qi)] == $past(cur_cnt) + CW'(1));
endmodule

// File: tb/llq_manager_test.sv
module llq_manager_test;
  localparam int CLK_P = 10;
  localparam int QBASE = 128;
  localparam int NQ = 64;
  localparam int NLINK = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_write;
  logic [15:0] cmd_addr;
  logic [31:0] cmd_wdata;
  logic cmd_ready, rsp_valid;
  logic [31:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  llq_manager uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  // behavioural reference model
  int unsigned mq [NQ][$];
  longint rb [4], rc [4], rs [4], rst [4];
  bit merr;

  task automatic check(string req, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bit mapped(longint a);
    for (int r = 0; r < 4; r++) begin
      longint sz = longint'(1) << rs[r];
      if (a >= rb[r] && (a - rb[r]) % sz == 0 && (a - rb[r]) / sz < rc[r] &&
          rst[r] + (a - rb[r]) / sz < NLINK) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit qok(int qn);
    return qn >= QBASE && qn < QBASE + NQ;
  endfunction

  // issue one command; checks busy cycle, then ready/response
  task automatic issue(bit wr, logic [15:0] a, logic [31:0] d, longint exp_rd, string req);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R9", cmd_ready, 0);
    @(negedge clk);
    check("R9", cmd_ready, 1);
    check("R9", rsp_valid, !wr);
    if (!wr) check(req, rsp_data, exp_rd);
  endtask

  task automatic push(int qn, int unsigned a, string req);
    issue(1'b1, {2'd0, 14'(qn)}, a, 0, req);
    if (qok(qn)) begin
      if (mapped(a)) mq[qn - QBASE].push_back(a);
      else merr = 1'b1;
    end
  endtask

  task automatic pop(int qn, string req);
    longint e = 0;
    if (qok(qn) && mq[qn - QBASE].size() > 0) e = mq[qn - QBASE].pop_front();
    issue(1'b0, {2'd1, 14'(qn)}, 0, e, req);
  endtask

  task automatic peek(int qn, string req);
    longint e = qok(qn) ? mq[qn - QBASE].size() : 0;
    issue(1'b0, {2'd2, 14'(qn)}, 0, e, req);
  endtask

  task automatic status(int w, string req);
    longint e = 0;
    for (int b = 0; b < 32; b++)
      if (w*32 + b < NQ && mq[w*32 + b].size() > 0) e |= longint'(1) << b;
    issue(1'b0, {2'd3, 2'd1, 12'(w)}, 0, e, req);
  endtask

  task automatic err_rd(string req);
    issue(1'b0, {2'd3, 2'd2, 12'd0}, 0, merr, req);
  endtask

  task automatic err_clear();
    issue(1'b1, {2'd3, 2'd2, 12'd0}, 0, 0, "R5");
    merr = 1'b0;
  endtask

  task automatic set_region(int r, longint b, longint c, longint s, longint st);
    issue(1'b1, {2'd3, 2'd0, 12'(r*4)},   32'(b), 0, "R10");
    issue(1'b1, {2'd3, 2'd0, 12'(r*4+1)}, 32'(c), 0, "R10");
    issue(1'b1, {2'd3, 2'd0, 12'(r*4+2)}, 32'(s), 0, "R10");
    issue(1'b1, {2'd3, 2'd0, 12'(r*4+3)}, 32'(st), 0, "R10");
    rb[r] = b; rc[r] = c; rs[r] = s; rst[r] = st;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 4; r++) begin rb[r] = 0; rc[r] = 0; rs[r] = 0; rst[r] = 0; end
    merr = 1'b0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", cmd_ready, 1);
    check("R9", rsp_valid, 0);
    peek(QBASE, "R6");
    status(0, "R7");
    err_rd("R5");
    issue(1'b0, {2'd3, 2'd0, 12'd1}, 0, 0, "R10");

    // no region configured: push refused
    push(QBASE, 32'h1000_0000, "R4");
    peek(QBASE, "R4");
    err_rd("R5");
    err_rd("R5");
    err_clear();
    err_rd("R5");

    set_region(0, 32'h1000_0000, 16, 7, 0);
    set_region(1, 32'h2000_0000, 64, 6, 16);
    set_region(2, 32'h3000_0000, 8, 4, 1020);
    set_region(3, 32'h1000_0000, 4, 7, 100);
    issue(1'b0, {2'd3, 2'd0, 12'd4}, 0, 32'h2000_0000, "R10");
    issue(1'b0, {2'd3, 2'd0, 12'd10}, 0, 4, "R10");
    issue(1'b0, {2'd3, 2'd0, 12'd15}, 0, 100, "R10");

    // FIFO order on one queue, plus others
    push(QBASE, 32'h1000_0080, "R1");
    push(QBASE, 32'h1000_0000, "R1");
    push(QBASE, 32'h1000_0780, "R1");
    push(QBASE + 1, 32'h2000_0040, "R1");
    push(QBASE + NQ - 1, 32'h3000_0030, "R4");
    peek(QBASE, "R6");
    peek(QBASE + NQ - 1, "R6");
    status(0, "R7");
    status(1, "R7");
    err_rd("R4");
    pop(QBASE, "R2");
    peek(QBASE, "R2");
    pop(QBASE, "R1");
    pop(QBASE, "R1");
    pop(QBASE, "R3");
    peek(QBASE, "R3");
    status(0, "R3");
    err_rd("R3");
    pop(QBASE + NQ - 1, "R2");
    pop(QBASE + 1, "R2");

    // refused pushes
    push(QBASE + 2, 32'h1000_0040, "R4");
    err_rd("R4");
    peek(QBASE + 2, "R4");
    err_clear();
    push(QBASE + 2, 32'h1000_0800, "R4");
    err_rd("R4");
    err_clear();
    push(QBASE + 2, 32'h3000_0040, "R4");
    err_rd("R4");
    err_clear();
    push(QBASE + 2, 32'h0FFF_FF80, "R4");
    peek(QBASE + 2, "R4");
    err_rd("R5");
    err_clear();

    // queue numbers outside the owned range
    push(QBASE - 1, 32'h2000_0000, "R8");
    push(QBASE + NQ, 32'h2000_0080, "R8");
    err_rd("R8");
    peek(QBASE - 1, "R8");
    pop(QBASE + NQ, "R8");
    status(0, "R8");

    // interleaved queues over the shared link RAM
    for (int i = 0; i < 40; i++) push(QBASE + 2 + (i % 8), 32'h2000_0000 + i * 64, "R11");
    for (int q = 0; q < 8; q++) peek(QBASE + 2 + q, "R6");
    status(0, "R7");
    for (int i = 0; i < 20; i++) pop(QBASE + 2 + ((i * 3) % 8), "R11");
    for (int i = 0; i < 20; i++) push(QBASE + 2 + (i % 5), 32'h1000_0000 + i * 128, "R11");
    for (int q = 0; q < 8; q++) begin
      for (int k = 0; k < 9; k++) pop(QBASE + 2 + q, "R11");
    end
    status(0, "R7");
    err_rd("R5");
    finish_run();
  end
endmodule